// File: doc/BRIEF.md
# Auto-Refresh Scheduler with Deferral Budget

This block decides when a two-bank SDRAM controller must issue auto-refresh commands. A free-running interval timer, clocked by the controller clock, marks each average refresh period. Every mark adds one owed refresh to a debt counter. While refreshes are owed and the command arbiter reports that it is idle, the block asks for a refresh. The arbiter answers with a one-cycle grant when it has actually issued the refresh command. Refreshes can therefore be put off while reads and writes keep the command path busy, and then paid back as a burst.

The debt may not grow without bound. When it reaches its ceiling (eight by default), the block raises an urgent flag. The arbiter must then stop accepting new reads or writes until a refresh has gone out. A minimum spacing equal to the refresh cycle time is enforced between accepted grants, and also after the memory leaves self refresh. A grant that breaks that spacing, or that arrives when nothing is owed, is not counted and is reported as a protocol error. All cycle counts are derived at elaboration from picosecond parameters by rounding up.

Top module: `rfsh_sched`

## Requirements
- R1: The refresh interval in clocks is ceil(REFI_PS / CLK_PS), and the refresh spacing in clocks is ceil(RFC_PS / CLK_PS). With the timer starting from reset release, the first increment of `debt` becomes visible after exactly one interval of rising edges.
- R2: `debt` resets to 0 and rises by one at the end of every interval, whatever the arbiter is doing.
- R3: `ref_req` is high when `debt` is nonzero, the spacing window is clear, and `arb_idle` is high. It is low while the arbiter is busy, unless the request is urgent.
- R4: A grant with a nonzero debt and a clear spacing window is accepted. It lowers `debt` by one at that edge and opens a spacing window that keeps `ref_req` low.
- R5: A grant that arrives inside a spacing window is ignored: `debt` is unchanged and `proto_err` is high for the single following cycle.
- R6: A grant that arrives while `debt` is 0 is ignored in the same way and pulses `proto_err`.
- R7: A one-cycle `sr_exit` pulse opens a spacing window of the same length. Grants inside that window are treated as in R5, including a grant that coincides with the pulse.
- R8: `ref_urgent` is high exactly while `debt` equals MAX_DEBT. While it is high and the window is clear, `ref_req` is high even when `arb_idle` is low.
- R9: `debt` saturates at MAX_DEBT. An interval end that finds `debt` already at MAX_DEBT sets `overflow_err`, which stays high until reset.
- R10: Synchronous active-low reset clears `debt`, `overflow_err`, `proto_err` and the spacing window, and restarts the interval timer.
- R11: A grant exactly one spacing period (in clocks) after the previous accepted grant is accepted. One clock earlier, it is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_idle | input | 1 | High when the command arbiter has no read or write to issue |
| ref_grant | input | 1 | One-cycle pulse: the arbiter issued an auto-refresh |
| sr_exit | input | 1 | One-cycle pulse: the memory has just left self refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_urgent | output | 1 | Debt at its ceiling; the arbiter must block new reads and writes |
| debt | output | DEBT_W (4) | Number of refreshes currently owed |
| overflow_err | output | 1 | Sticky: an interval elapsed while the debt was full |
| proto_err | output | 1 | One-cycle pulse after a grant that was ignored |

## Verification
The debt counter moves on the same rising edge that samples an interval end or an accepted grant. `ref_req` and `ref_urgent` follow combinationally from the registered debt and spacing window, so their new values are valid in the cycle right after that edge. `proto_err` is registered from the rejected grant, so it is high only in the one cycle after that grant's edge. The spacing window closes exactly one refresh spacing after the edge that opened it. The bench drives inputs at falling edges, counts the rising edges since reset release, and samples every output at the falling edge that follows the counted rising edge. Each table row is placed at the exact edge where one of these values is due, or one edge before it.

// File: rtl/rfsh_sched_pkg.sv
// Package: rfsh_sched_pkg
// Shared helpers for the refresh scheduler. Cycle counts are derived from
// picosecond timing values by rounding up, so that no minimum is shortened.
package rfsh_sched_pkg;

    // Integer ceiling division, used on elaboration-time constants only.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Counter width able to hold values 0 .. max_val, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: rfsh_interval_timer
// Free-running divider that gives a one-cycle tick every PERIOD_CYC clocks.
// Assumes: PERIOD_CYC >= 1. After reset release the first tick is high
// during the cycle that ends with the PERIOD_CYC-th rising edge.
module rfsh_interval_timer
    import rfsh_sched_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 1950
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int unsigned CW = cnt_width(PERIOD_CYC - 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Tick while the count sits on its last value.
    assign tick = (cnt_q == LAST);

    // Count the clocks of one interval, then wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (PERIOD_CYC > 1) begin : g_tick_chk
            // R2: interval ends are isolated pulses, never back to back
            a_r2_tick_isolated: assert property (
                @(posedge clk) disable iff (!rst_n) tick |=> !tick
            );
        end
    endgenerate

endmodule

// File: rtl/rfsh_holdoff.sv
// Module: rfsh_holdoff
// Spacing window after an accepted refresh or a self-refresh exit. A start
// pulse blocks for HOLD_CYC clocks, counting the start edge. A later start
// restarts the window.
// Assumes: HOLD_CYC >= 1. With HOLD_CYC == 1 the window never blocks.
module rfsh_holdoff
    import rfsh_sched_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clear
);

    localparam int unsigned HW = cnt_width(HOLD_CYC - 1);
    localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC - 1);

    logic [HW-1:0] left_q;

    // The window is open for grants once the remaining count is zero.
    assign clear = (left_q == '0);

    // Load on start, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (start)
            left_q <= LOAD;
        else if (!clear)
            left_q <= left_q - 1'b1;
    end

    generate
        if (HOLD_CYC > 1) begin : g_hold_chk
            // R7: any start leaves the window blocked in the next cycle
            a_r7_start_blocks: assert property (
                @(posedge clk) disable iff (!rst_n) start |=> !clear
            );
        end
    endgenerate

endmodule

// File: rtl/rfsh_debt_ctr.sv
// Module: rfsh_debt_ctr
// Saturating count of owed refreshes with a sticky overflow flag.
// Assumes: take is only raised while the debt is nonzero (the top ensures this).
// An interval end and a take in the same cycle cancel out.
module rfsh_debt_ctr
    import rfsh_sched_pkg::*;
#(
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned DW = cnt_width(MAX_DEBT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          take,
    output logic [DW-1:0] debt,
    output logic          full,
    output logic          overflow
);

    localparam logic [DW-1:0] CEIL = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;
    logic          ovf_q;

    assign debt     = debt_q;
    assign full     = (debt_q == CEIL);
    assign overflow = ovf_q;

    // Add on an interval end, subtract on a take, and saturate at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            debt_q <= '0;
        else begin
            case ({tick, take})
                2'b10:   if (!full) debt_q <= debt_q + 1'b1;
                2'b01:   debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end

    // Latch an interval end that finds the debt already full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (tick && full)
            ovf_q <= 1'b1;
    end

    // R9: the debt never passes its ceiling
    a_r9_debt_bounded: assert property (
        @(posedge clk) disable iff (!rst_n) debt_q <= CEIL
    );

    // R9: overflow, once set, stays set until reset
    a_r9_overflow_sticky: assert property (
        @(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q
    );

    // R6: a take never arrives with nothing owed
    a_r6_no_underflow: assert property (
        @(posedge clk) disable iff (!rst_n) take |-> (debt_q != '0)
    );

    // R2: the debt moves by at most one per clock
    a_r2_unit_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((debt_q == $past(debt_q)) ||
                  (debt_q == $past(debt_q) + 1'b1) ||
                  (debt_q == $past(debt_q) - 1'b1))
    );

endmodule

// File: rtl/rfsh_sched.sv
// Module: rfsh_sched (top)
// Auto-refresh scheduler. It counts owed refreshes, requests them while the
// arbiter is idle, forces them at the debt ceiling, and enforces the
// refresh spacing between accepted grants and after self-refresh exit.
// Assumes: ref_grant and sr_exit are one-cycle pulses. Precharging the banks
// and encoding the commands are done by the arbiter.
module rfsh_sched
    import rfsh_sched_pkg::*;
#(
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned REFI_PS  = 15_600_000,
    parameter int unsigned RFC_PS   = 90_000,
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned DEBT_W  = cnt_width(MAX_DEBT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_idle,
    input  logic              ref_grant,
    input  logic              sr_exit,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [DEBT_W-1:0] debt,
    output logic              overflow_err,
    output logic              proto_err
);

    localparam int unsigned REFI_CYC = ceil_div(REFI_PS, CLK_PS);
    localparam int unsigned RFC_CYC  = ceil_div(RFC_PS, CLK_PS);

    logic tick;
    logic hold_clear;
    logic full;
    logic take;
    logic owed;
    logic perr_q;

    rfsh_interval_timer #(.PERIOD_CYC(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfsh_holdoff #(.HOLD_CYC(RFC_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (take || sr_exit),
        .clear (hold_clear)
    );

    rfsh_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .take     (take),
        .debt     (debt),
        .full     (full),
        .overflow (overflow_err)
    );

    assign owed = (debt != '0);

    // Accept a grant only with debt owed, the window clear and no exit pulse.
    assign take = ref_grant && owed && hold_clear && !sr_exit;

    // Request when owed and spaced; at the ceiling ignore the arbiter's busy state.
    assign ref_req    = owed && hold_clear && (arb_idle || full);
    assign ref_urgent = full;
    assign proto_err  = perr_q;

    // Flag, one cycle later, every grant that was not accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perr_q <= 1'b0;
        else
            perr_q <= ref_grant && !take;
    end

    // R5: an error pulse always follows a grant on the previous edge
    a_r5_error_has_grant: assert property (
        @(posedge clk) disable iff (!rst_n) proto_err |-> $past(ref_grant)
    );

    generate
        if (RFC_CYC > 1) begin : g_req_chk
            // R4: after an accepted grant the request drops for the window
            a_r4_req_drops: assert property (
                @(posedge clk) disable iff (!rst_n) take |=> !ref_req
            );
        end
    endgenerate

endmodule

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
// Bench for rfsh_sched. Timing is shortened: the interval is 20 clocks
// (152001 ps rounded up) and the spacing is 7 clocks (50000 ps rounded up).
module rfsh_sched_tb;

    typedef struct packed {
        logic [8:0] n;      // rising edges to run; grant/exit only on the first
        logic       idle;
        logic       gnt;
        logic       srx;
        logic [3:0] debt;
        logic       req;
        logic       urg;
        logic       perr;
        logic       ovf;
        logic [3:0] tag;    // requirement number printed on failure
    } vec_t;

    localparam int NV = 24;

    // t below = rising edges since reset release at the moment of the check
    localparam vec_t VECS [0:NV-1] = '{
        '{9'd19, 1'b0,1'b0,1'b0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 4'd1},  // t=19 R1 no tick yet
        '{9'd1,  1'b0,1'b0,1'b0, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd2},  // t=20 R2 first tick, busy
        '{9'd1,  1'b1,1'b0,1'b0, 4'd1, 1'b1,1'b0,1'b0,1'b0, 4'd3},  // t=21 R3 idle -> request
        '{9'd1,  1'b1,1'b1,1'b0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 4'd4},  // t=22 R4 accepted
        '{9'd7,  1'b1,1'b0,1'b0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 4'd4},  // t=29 window closed, nothing owed
        '{9'd1,  1'b1,1'b1,1'b0, 4'd0, 1'b0,1'b0,1'b1,1'b0, 4'd6},  // t=30 R6 grant with no debt
        '{9'd10, 1'b0,1'b0,1'b0, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd2},  // t=40 R2 second tick
        '{9'd20, 1'b0,1'b0,1'b0, 4'd2, 1'b0,1'b0,1'b0,1'b0, 4'd2},  // t=60 R2 debt 2
        '{9'd1,  1'b1,1'b1,1'b0, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd4},  // t=61 R4 accept opens window
        '{9'd1,  1'b1,1'b1,1'b0, 4'd1, 1'b0,1'b0,1'b1,1'b0, 4'd5},  // t=62 R5 grant in window
        '{9'd4,  1'b1,1'b0,1'b0, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // t=66 R5 still spacing
        '{9'd1,  1'b1,1'b0,1'b0, 4'd1, 1'b1,1'b0,1'b0,1'b0, 4'd11}, // t=67 R11 window just cleared
        '{9'd1,  1'b1,1'b1,1'b0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 4'd11}, // t=68 R11 accepted at spacing 7
        '{9'd12, 1'b0,1'b0,1'b0, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd3},  // t=80 R3 owed but busy
        '{9'd1,  1'b1,1'b0,1'b1, 4'd1, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // t=81 R7 self-refresh exit
        '{9'd1,  1'b1,1'b1,1'b0, 4'd1, 1'b0,1'b0,1'b1,1'b0, 4'd7},  // t=82 R7 grant too soon
        '{9'd5,  1'b1,1'b0,1'b0, 4'd1, 1'b1,1'b0,1'b0,1'b0, 4'd7},  // t=87 R7 window over
        '{9'd1,  1'b1,1'b1,1'b0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 4'd4},  // t=88 R4 accepted
        '{9'd151,1'b0,1'b0,1'b0, 4'd7, 1'b0,1'b0,1'b0,1'b0, 4'd8},  // t=239 R8 seven owed, busy
        '{9'd1,  1'b0,1'b0,1'b0, 4'd8, 1'b1,1'b1,1'b0,1'b0, 4'd8},  // t=240 R8 urgent overrides busy
        '{9'd1,  1'b0,1'b1,1'b0, 4'd7, 1'b0,1'b0,1'b0,1'b0, 4'd8},  // t=241 R8 urgent cleared by grant
        '{9'd19, 1'b0,1'b0,1'b0, 4'd8, 1'b1,1'b1,1'b0,1'b0, 4'd9},  // t=260 R9 full again
        '{9'd20, 1'b0,1'b0,1'b0, 4'd8, 1'b1,1'b1,1'b0,1'b1, 4'd9},  // t=280 R9 saturate + overflow
        '{9'd1,  1'b0,1'b1,1'b0, 4'd7, 1'b0,1'b0,1'b0,1'b1, 4'd9}   // t=281 R9 overflow sticky
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_idle = 1'b0;
    logic       ref_grant = 1'b0;
    logic       sr_exit = 1'b0;
    logic       ref_req;
    logic       ref_urgent;
    logic [3:0] debt;
    logic       overflow_err;
    logic       proto_err;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rfsh_sched #(
        .CLK_PS   (8000),
        .REFI_PS  (152_001),
        .RFC_PS   (50_000),
        .MAX_DEBT (8)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .arb_idle     (arb_idle),
        .ref_grant    (ref_grant),
        .sr_exit      (sr_exit),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .debt         (debt),
        .overflow_err (overflow_err),
        .proto_err    (proto_err)
    );

    // Compare every output with the expected set; one line per miscompare.
    task automatic check(input int idx, input int tag, input logic [3:0] e_debt,
                         input logic e_req, input logic e_urg,
                         input logic e_perr, input logic e_ovf);
        n_vec++;
        if (debt !== e_debt || ref_req !== e_req || ref_urgent !== e_urg ||
            proto_err !== e_perr || overflow_err !== e_ovf) begin
            n_fail++;
            $display("FAIL R%0d step %0d: debt=%0d req=%b urg=%b perr=%b ovf=%b, expected debt=%0d req=%b urg=%b perr=%b ovf=%b",
                     tag, idx, debt, ref_req, ref_urgent, proto_err, overflow_err,
                     e_debt, e_req, e_urg, e_perr, e_ovf);
        end
    endtask

    // Apply inputs for n rising edges; pulses last only for the first edge.
    task automatic run(input int n, input logic idle, input logic gnt, input logic srx);
        arb_idle  = idle;
        ref_grant = gnt;
        sr_exit   = srx;
        @(posedge clk);
        @(negedge clk);
        ref_grant = 1'b0;
        sr_exit   = 1'b0;
        for (int k = 1; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: state held in reset
        repeat (3) @(negedge clk);
        check(-1, 10, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            run(int'(VECS[i].n), VECS[i].idle, VECS[i].gnt, VECS[i].srx);
            check(i, int'(VECS[i].tag), VECS[i].debt, VECS[i].req,
                  VECS[i].urg, VECS[i].perr, VECS[i].ovf);
        end

        // R10: reset mid-run clears debt and the sticky overflow flag
        rst_n = 1'b0;
        arb_idle = 1'b1;
        repeat (2) @(negedge clk);
        check(100, 10, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: the timer restarts, so the first tick again lands on edge 20
        run(19, 1'b1, 1'b0, 1'b0);
        check(101, 1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run(1, 1'b1, 1'b0, 1'b0);
        check(102, 1, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule